// File: doc/BRIEF.md
# Violation-Learning Handling Mode Selector

This block sits beside a speculation directory and learns which memory lines keep producing cross-thread dependence trouble. Every report of a potential violation, or of a real violation that forced a squash, carries a line address. The block keeps a small fully associative table of such lines. Each entry holds a weighted event counter and a handling mode. When the counter reaches a threshold, the line's mode climbs one rung of a fixed five-rung ladder toward more cautious handling. A periodic age tick walks every remembered line one rung back down. A line that ages out of the bottom rung is forgotten.

The requesting logic presents a line address on a lookup port and gets back, in the same cycle, the mode to apply to that line. Lines the table does not hold report plain speculation. Reports arrive on a valid/ready channel. The block lowers ready only in a cycle where the age tick is high; any report offered in that cycle is not taken and must be held by the sender. The lookup port and the age tick are plain pins with no handshake.

Top module: `vlearn_mode_sel`

## Requirements
- R1: After reset the table is empty, so every lookup returns mode 0.
- R2: `lk_mode` gives the stored mode for a line held in the table and 0 for any other line. The mode codes are 0 plain speculation, 1 delay-and-disambiguate, 2 value predict, 3 stall-and-release, 4 stall-and-wait.
- R3: An accepted report adds 1 to the line's counter when `evt_sev` is 0 (potential violation) and 2 when `evt_sev` is 1 (violation with squash).
- R4: If the sum reaches `THRESH`, the mode rises by exactly one and the counter clears; otherwise the counter takes the sum and the mode is unchanged.
- R5: At mode 4 a report that reaches `THRESH` leaves the mode at 4 and clears the counter.
- R6: A report for a line not in the table allocates an entry that starts at mode 0 with count 0, and the R3/R4 update is then applied to it.
- R7: On an age tick, every held line with a mode above 0 drops one mode and clears its counter. Every held line already at mode 0 is removed.
- R8: `evt_ready` is low exactly in cycles where `age_tick` is high, and a report offered then changes nothing.
- R9: When all `NENT` entries are full, a new line replaces the entry whose last accepted report is oldest. Lookups and age ticks do not count as use.
- R10: A line occupies at most one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| age_tick | input | 1 | Periodic aging pulse |
| evt_valid | input | 1 | Report offered |
| evt_ready | output | 1 | Report can be accepted this cycle |
| evt_sev | input | 1 | 0 potential violation, 1 violation with squash |
| evt_line | input | LINE_W | Line address of the report |
| lk_line | input | LINE_W | Line address to look up |
| lk_mode | output | 3 | Handling mode for `lk_line` |

## Verification
The assertions rely on `age_tick`, `evt_valid` and the line buses never being X or Z after reset, and on reset being applied from the first clock edge. `THRESH` must lie between 1 and 2**CNT_W-1. The bench holds every control input at a defined value from time zero and drives a pseudo-random mix of reports, ticks and ticks colliding with reports. The reports use a pool of six lines against four entries, so eviction, re-allocation and aging-out all occur. After every step it compares the mode of every pool line, plus one line that is never reported, with an arithmetic model.

// File: rtl/vlearn_pkg.sv
package vlearn_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_PLAIN      = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DELAY      = 3'd1;
  localparam logic [MODE_W-1:0] MODE_VPRED      = 3'd2;
  localparam logic [MODE_W-1:0] MODE_STALL_REL  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_STALL_WAIT = 3'd4;
  localparam logic [MODE_W-1:0] MODE_TOP        = MODE_STALL_WAIT;
endpackage

// File: rtl/vlearn_match.sv
module vlearn_match #(
  parameter int NENT   = 4,
  parameter int LINE_W = 16,
  parameter int IDX_W  = $clog2(NENT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NENT-1:0]              valid,
  input  logic [NENT-1:0][LINE_W-1:0]  tags,
  input  logic [LINE_W-1:0]            key,
  output logic [NENT-1:0]              hit_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NENT; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R10
endmodule

// File: rtl/vlearn_ladder.sv
module vlearn_ladder
  import vlearn_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int THRESH = 3
) (
  input  logic [MODE_W-1:0] mode_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              sev,
  output logic [MODE_W-1:0] mode_out,
  output logic [CNT_W-1:0]  cnt_out
);
  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, cnt_in} + (sev ? SUM_W'(2) : SUM_W'(1));

  always_comb begin
    if (int'(sum) >= THRESH) begin
      mode_out = (mode_in == MODE_TOP) ? MODE_TOP : mode_in + 3'd1;
      cnt_out  = '0;
    end else begin
      mode_out = mode_in;
      cnt_out  = sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/vlearn_lru.sv
module vlearn_lru #(
  parameter int NENT  = 4,
  parameter int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NENT-1:0]  valid,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_alloc,
  input  logic [NENT-1:0]  drop_vec,
  output logic [IDX_W-1:0] victim_idx
);
  logic [NENT-1:0][IDX_W-1:0] rank_q;
  logic [NENT-1:0][IDX_W-1:0] dec_n;
  logic [NENT-1:0]            oldest_vec;
  logic [IDX_W:0]             nvalid;
  logic [IDX_W:0]             ref_rank;
  logic                       full;
  logic                       found;

  always_comb begin
    nvalid = '0;
    for (int i = 0; i < NENT; i++) nvalid = nvalid + {{IDX_W{1'b0}}, valid[i]};
  end
  assign full = (int'(nvalid) == NENT);

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_old
      assign oldest_vec[g] = valid[g] && (rank_q[g] == IDX_W'(NENT-1));
    end
  endgenerate

  always_comb begin
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (!found && (full ? oldest_vec[i] : !valid[i])) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign ref_rank = touch_alloc ? nvalid : {1'b0, rank_q[touch_idx]};

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      dec_n[i] = '0;
      for (int j = 0; j < NENT; j++)
        if (drop_vec[j] && rank_q[j] < rank_q[i]) dec_n[i] = dec_n[i] + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rank_q <= '0;
    end else if (touch) begin
      for (int i = 0; i < NENT; i++) begin
        if (IDX_W'(i) == touch_idx)
          rank_q[i] <= '0;
        else if (valid[i] && ({1'b0, rank_q[i]} < ref_rank))
          rank_q[i] <= rank_q[i] + IDX_W'(1);
      end
    end else if (|drop_vec) begin
      for (int i = 0; i < NENT; i++) rank_q[i] <= rank_q[i] - dec_n[i];
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ($countones(oldest_vec) == 1)); // R9
endmodule

// File: rtl/vlearn_mode_sel.sv
module vlearn_mode_sel
  import vlearn_pkg::*;
#(
  parameter int NENT   = 4,
  parameter int LINE_W = 16,
  parameter int CNT_W  = 3,
  parameter int THRESH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              age_tick,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_sev,
  input  logic [LINE_W-1:0] evt_line,
  input  logic [LINE_W-1:0] lk_line,
  output logic [MODE_W-1:0] lk_mode
);
  localparam int IDX_W = $clog2(NENT);

  logic [NENT-1:0]              valid_q;
  logic [NENT-1:0][LINE_W-1:0]  tag_q;
  logic [NENT-1:0][MODE_W-1:0]  mode_q;
  logic [NENT-1:0][CNT_W-1:0]   cnt_q;

  logic                         evt_fire;
  logic [NENT-1:0]              ev_vec, lk_vec, drop_vec;
  logic                         ev_hit, lk_hit;
  logic [IDX_W-1:0]             ev_idx, lk_idx, victim_idx, slot;
  logic [MODE_W-1:0]            cur_mode, nxt_mode;
  logic [CNT_W-1:0]             cur_cnt, nxt_cnt;

  assign evt_ready = !age_tick;
  assign evt_fire  = evt_valid && evt_ready;

  vlearn_match #(.NENT(NENT), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_ev_match (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .tags(tag_q), .key(evt_line),
    .hit_vec(ev_vec), .hit(ev_hit), .hit_idx(ev_idx));

  vlearn_match #(.NENT(NENT), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .tags(tag_q), .key(lk_line),
    .hit_vec(lk_vec), .hit(lk_hit), .hit_idx(lk_idx));

  assign lk_mode = lk_hit ? mode_q[lk_idx] : MODE_PLAIN;

  assign slot     = ev_hit ? ev_idx : victim_idx;
  assign cur_mode = ev_hit ? mode_q[ev_idx] : MODE_PLAIN;
  assign cur_cnt  = ev_hit ? cnt_q[ev_idx] : '0;

  vlearn_ladder #(.CNT_W(CNT_W), .THRESH(THRESH)) u_ladder (
    .mode_in(cur_mode), .cnt_in(cur_cnt), .sev(evt_sev),
    .mode_out(nxt_mode), .cnt_out(nxt_cnt));

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_drop
      assign drop_vec[g] = age_tick && valid_q[g] && (mode_q[g] == MODE_PLAIN);
    end
  endgenerate

  vlearn_lru #(.NENT(NENT), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .touch(evt_fire),
    .touch_idx(slot), .touch_alloc(!ev_hit), .drop_vec(drop_vec),
    .victim_idx(victim_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      mode_q  <= '0;
      cnt_q   <= '0;
    end else if (age_tick) begin
      for (int i = 0; i < NENT; i++) begin
        if (valid_q[i]) begin
          if (mode_q[i] == MODE_PLAIN) valid_q[i] <= 1'b0;
          else mode_q[i] <= mode_q[i] - 3'd1;
          cnt_q[i] <= '0;
        end
      end
    end else if (evt_fire) begin
      valid_q[slot] <= 1'b1;
      tag_q[slot]   <= evt_line;
      mode_q[slot]  <= nxt_mode;
      cnt_q[slot]   <= nxt_cnt;
    end
  end

  generate
    for (g = 0; g < NENT; g++) begin : g_chk
      AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_fire) && $past(valid_q[g]) && valid_q[g] && (tag_q[g] == $past(tag_q[g])))
        |-> ((mode_q[g] == $past(mode_q[g])) || (mode_q[g] == $past(mode_q[g]) + 3'd1))); // R4
      AST_AGE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(age_tick) && $past(valid_q[g]) && ($past(mode_q[g]) != MODE_PLAIN))
        |-> (valid_q[g] && (mode_q[g] == $past(mode_q[g]) - 3'd1) && (cnt_q[g] == '0))); // R7
      AST_AGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(age_tick) && $past(valid_q[g]) && ($past(mode_q[g]) == MODE_PLAIN))
        |-> !valid_q[g]); // R7
      AST_MODE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[g] |-> (mode_q[g] <= MODE_TOP)); // R5
    end
  endgenerate

  AST_TICK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (age_tick && evt_valid && !$past(age_tick)) |=> $stable(tag_q)); // R8
endmodule

// File: tb/vlearn_mode_sel_tb_top.sv
`timescale 1ns/1ps
module vlearn_mode_sel_tb_top;
  localparam int NENT = 4, LINE_W = 16, CNT_W = 3, THRESH = 3, NL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic age_tick = 1'b0, evt_valid = 1'b0, evt_sev = 1'b0;
  logic [LINE_W-1:0] evt_line = '0, lk_line = '0;
  logic evt_ready;
  logic [2:0] lk_mode;

  always #2 clk = ~clk;

  vlearn_mode_sel #(.NENT(NENT), .LINE_W(LINE_W), .CNT_W(CNT_W), .THRESH(THRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .age_tick(age_tick), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_sev(evt_sev), .evt_line(evt_line),
    .lk_line(lk_line), .lk_mode(lk_mode));

  bit mv[NL];
  int mm[NL], mc[NL], ms[NL];
  int stamp = 0, nchk = 0, nfail = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [LINE_W-1:0] addr(int k);
    return LINE_W'(16'h0A40 + k * 16'h0113);
  endfunction

  task automatic note(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_event(int k, bit sev);
    int nv, sum, old;
    if (!mv[k]) begin
      nv = 0;
      old = -1;
      for (int j = 0; j < NL; j++) if (mv[j]) begin
        nv++;
        if (old < 0 || ms[j] < ms[old]) old = j;
      end
      if (nv == NENT) mv[old] = 0;   // R9 oldest use replaced
      mv[k] = 1; mm[k] = 0; mc[k] = 0; // R6
    end
    sum = mc[k] + (sev ? 2 : 1);      // R3
    if (sum >= THRESH) begin          // R4, R5
      if (mm[k] < 4) mm[k]++;
      mc[k] = 0;
    end else mc[k] = sum;
    stamp++;
    ms[k] = stamp;
  endtask

  task automatic m_tick();
    for (int j = 0; j < NL; j++) if (mv[j]) begin   // R7
      if (mm[j] == 0) mv[j] = 0;
      else begin mm[j]--; mc[j] = 0; end
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NL; k++) begin
      lk_line = addr(k);
      #0.2;
      note(int'(lk_mode) == (mv[k] ? mm[k] : 0), req, int'(lk_mode), mv[k] ? mm[k] : 0);
    end
    lk_line = 16'hFFFF;
    #0.2;
    note(lk_mode == 3'd0, "R2 unheld line", int'(lk_mode), 0);
  endtask

  task automatic step(int k, bit sev, bit ev, bit tick, string req);
    @(negedge clk);
    evt_valid = ev; evt_sev = sev; evt_line = addr(k); age_tick = tick;
    #0.3;
    note(evt_ready == !tick, "R8 ready", int'(evt_ready), int'(!tick));
    @(posedge clk);
    if (tick) m_tick();
    else if (ev) m_event(k, sev);
    @(negedge clk);
    evt_valid = 0; age_tick = 0;
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NL; k++) begin mv[k] = 0; mm[k] = 0; mc[k] = 0; ms[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1 reset empty");
    // R3 R4 R6: potential reports count by one
    step(0, 0, 1, 0, "R6 alloc");
    step(0, 0, 1, 0, "R3 weight one");
    step(0, 0, 1, 0, "R4 climb");
    // R3: squash weight two
    step(1, 1, 1, 0, "R3 weight two");
    step(1, 1, 1, 0, "R4 climb two");
    // R5: drive line 0 to the top and beyond
    for (int i = 0; i < 14; i++) step(0, 1, 1, 0, "R5 cap");
    // R8: report colliding with tick is ignored
    step(2, 1, 1, 1, "R8 ignored");
    step(2, 1, 1, 0, "R6 after tick");
    // R9: fill table with climbed lines, then evict
    for (int k = 2; k < 4; k++) for (int i = 0; i < 2; i++) step(k, 1, 1, 0, "R9 fill");
    step(1, 1, 1, 0, "R9 touch");
    step(4, 1, 1, 0, "R9 evict");
    step(5, 1, 1, 0, "R9 evict");
    // R7: ticks bring everything down and out
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, "R7 aging");
    // sweep
    for (int n = 0; n < 3000; n++) begin
      int op, k;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = int'(lfsr[3:0]);
      k = int'(lfsr[7:4]) % NL;
      if (op == 0) step(k, lfsr[8], 1, 1, "R8 R7 sweep");
      else if (op == 1) step(k, 0, 0, 1, "R7 sweep");
      else step(k, lfsr[8], 1, 0, "R2 R4 R9 R10 sweep");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule